// File: doc/BRIEF.md
# SHA-256 Final-Block Padder

This unit sits in front of a SHA-256 compression engine and turns a byte stream into complete 64-byte blocks. A transfer starts with a one-cycle `start` pulse while the unit is idle. At that pulse the unit captures the mode bit, the residual byte count and the 64-bit message length in bits, which arrives as two 32-bit words. Without padding, the unit forwards exactly one 64-byte block from the input to the output unchanged.

With padding enabled, the unit takes only the residual bytes of the final block, 0 to 64 of them, from the input. After the last data byte it inserts the 0x80 marker and then zero bytes. It closes the final block with the bit length, most significant byte first. When the residual leaves no room for the marker plus the eight length bytes, the unit emits a second block. Every output byte of the final emitted block carries a last flag, so the engine reports a result only after that block. A block-end flag marks every 64th byte.

Both sides use valid/ready handshakes. Data bytes flow through combinationally, so an input byte is taken only in the same cycle that the engine takes it.

Top module: `sha256_pad_unit`

## Requirements
- R1: After reset, `idle` is 1 and `out_valid` and `in_ready` are 0.
- R2: With `pad_en` 0, exactly 64 input bytes appear unchanged and in order on the output as one block. `res_bytes` and the length words have no effect, and `idle` returns to 1 after byte 63.
- R3: With `pad_en` 1 and a residual r below 56, one block is emitted. Its bytes 0..r-1 are the input bytes, byte r is 0x80, the bytes from r+1 to 55 are 0x00, and bytes 56..63 carry the length.
- R4: With `pad_en` 1 and r from 56 to 63, two blocks are emitted (128 bytes). Byte r is 0x80, bytes r+1..119 are 0x00, and bytes 120..127 carry the length. `out_last` is 0 throughout the first block and 1 throughout the second.
- R5: With r equal to 64, the first block is the 64 input bytes. The second block holds 0x80 at its first byte, then zeros, then the length.
- R6: With r equal to 0, no input byte is taken, and the single block starts with 0x80.
- R7: The eight length bytes are {`len_hi`,`len_lo`} in big-endian order. The k-th length byte (k = 0..7) is bits [63-8k -: 8].
- R8: A `res_bytes` value above 64 is treated as 64.
- R9: `in_ready` equals `out_ready` while a data byte is pending and is 0 otherwise. `out_valid` follows `in_valid` for data bytes and is 1 for generated bytes. Exactly r input bytes are taken in padding mode.
- R10: `out_eob` is 1 exactly on output bytes 63 and 127 of a transfer.
- R11: A `start` pulse and any changes to `pad_en`, `res_bytes` or the length words while a transfer is in progress have no effect on that transfer.
- R12: While `out_ready` is 0, the offered byte and its flags stay unchanged until they are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a transfer when idle |
| pad_en | input | 1 | 1 = final block with padding, 0 = one plain block |
| res_bytes | input | 7 | Residual byte count of the final block (0..64, larger saturates) |
| len_lo | input | 32 | Message bit length, low word |
| len_hi | input | 32 | Message bit length, high word |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte taken this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte to the engine |
| out_ready | input | 1 | Engine takes the output byte |
| out_last | output | 1 | Byte belongs to the final emitted block |
| out_eob | output | 1 | Byte is the last of a 64-byte block |
| idle | output | 1 | No transfer in progress |

## Verification
The hardest cases to reach are the residuals from 56 to 64. Only these make the unit add a second block, and the marker and the length then land in different blocks. A random residual alone hits them seldom, so the bench runs each edge directly: 0, 55, 56, 63, 64 and an over-range value. It then adds random residuals and random length words. Bubbles on `in_valid` and stalls on `out_ready` are randomized throughout, so that each pad byte is seen held under backpressure. One transfer also scrambles `start` and the captured controls on every cycle while it is busy.

// File: rtl/sha256_pad_unit.sv
module sha256_pad_unit #(
  parameter int BLK_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        pad_en,
  input  logic [6:0]  res_bytes,
  input  logic [31:0] len_lo,
  input  logic [31:0] len_hi,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  input  logic        out_ready,
  output logic        out_last,
  output logic        out_eob,
  output logic        idle
);
  localparam int LEN_BYTES = 8;
  localparam int ROOM      = BLK_BYTES - LEN_BYTES;
  localparam int BW        = $clog2(BLK_BYTES);
  localparam int PW        = BW + 1;
  localparam int LIW       = $clog2(LEN_BYTES);

  logic          busy_q, pad_q, two_q;
  logic [6:0]    cnt_q;
  logic [63:0]   len_q;
  logic [PW-1:0] pos_q;

  logic [6:0]    res_eff;
  logic [PW-1:0] last_pos, tail_start, tail_off;
  logic [LIW-1:0] len_idx;
  logic [63:0]   len_sh;
  logic          need_in, in_tail, fire;
  logic [7:0]    pad_byte;

  assign res_eff    = (res_bytes > 7'(BLK_BYTES)) ? 7'(BLK_BYTES) : res_bytes;
  assign last_pos   = two_q ? PW'(2*BLK_BYTES-1) : PW'(BLK_BYTES-1);
  assign tail_start = last_pos - PW'(LEN_BYTES-1);
  assign in_tail    = pos_q >= tail_start;
  assign tail_off   = pos_q - tail_start;
  assign len_idx    = tail_off[LIW-1:0];
  assign len_sh     = len_q >> {LIW'(LEN_BYTES-1) - len_idx, 3'b000};

  assign need_in  = busy_q && (!pad_q || (PW'(cnt_q) > pos_q));
  assign pad_byte = (pos_q == PW'(cnt_q)) ? 8'h80 : (in_tail ? len_sh[7:0] : 8'h00);

  assign out_data  = need_in ? in_data : pad_byte;
  assign out_valid = busy_q && (!need_in || in_valid);
  assign in_ready  = need_in && out_ready;
  assign fire      = out_valid && out_ready;
  assign out_eob   = busy_q && (pos_q[BW-1:0] == {BW{1'b1}});
  assign out_last  = busy_q && (!two_q || pos_q[BW]);
  assign idle      = !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pad_q  <= 1'b0;
      two_q  <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
      pos_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        pad_q  <= pad_en;
        two_q  <= pad_en && (res_eff >= 7'(ROOM));
        cnt_q  <= res_eff;
        len_q  <= {len_hi, len_lo};
        pos_q  <= '0;
      end
    end else if (fire) begin
      if (pos_q == last_pos) busy_q <= 1'b0;
      else                   pos_q  <= pos_q + 1'b1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> idle); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!out_valid && !in_ready)); // R9
  AST_IN_NEEDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_ready); // R9
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start) |=> !idle); // R11
  AST_HOLD_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !in_ready && !need_in) |=>
      (out_valid && $stable(out_data) && $stable(out_last) && $stable(out_eob))); // R12
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_eob && out_last) |=> idle); // R10
endmodule

// File: tb/sha256_pad_unit_tb.sv
`timescale 1ns/1ps
module sha256_pad_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, pad_en = 1'b0;
  logic [6:0] res_bytes = '0;
  logic [31:0] len_lo = '0, len_hi = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, out_last, out_eob, idle;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] msg [64];

  always #2.5 clk = ~clk;

  sha256_pad_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pad_en(pad_en), .res_bytes(res_bytes),
    .len_lo(len_lo), .len_hi(len_hi), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .out_last(out_last), .out_eob(out_eob), .idle(idle));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp<=150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int k, bit pad, int r, logic [63:0] len);
    int total;
    total = (pad && r >= 56) ? 128 : 64;
    if (!pad || k < r) return msg[k];
    if (k == r) return 8'h80;
    if (k >= total - 8) return 8'(len >> (8 * (total - 1 - k)));
    return 8'h00;
  endfunction

  task automatic run(input bit pad, input int res, input logic [31:0] lo, input logic [31:0] hi,
                     input bit noisy, input string tag);
    int r, total, k, guard;
    bit need;
    logic [63:0] len;
    string t;
    r = (res > 64) ? 64 : res;
    total = (pad && r >= 56) ? 128 : 64;
    len = {hi, lo};
    for (int i = 0; i < 64; i++) msg[i] = 8'($urandom);
    @(negedge clk);
    start = 1'b1; pad_en = pad; res_bytes = 7'(res); len_lo = lo; len_hi = hi;
    in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    k = 0; guard = 0;
    while (k < total && guard < 4000) begin
      guard++;
      need = !pad || (k < r);
      in_valid = need && ($urandom % 4 != 0);
      in_data  = need ? msg[k] : 8'($urandom);
      out_ready = ($urandom % 3 != 0);
      if (noisy) begin
        start = 1'($urandom); pad_en = 1'($urandom); res_bytes = 7'($urandom);
        len_lo = $urandom; len_hi = $urandom;
      end
      #1;
      chk(out_valid == (need ? in_valid : 1'b1), "R9 out_valid", out_valid, need ? in_valid : 1'b1);
      chk(in_ready == (need && out_ready), "R9 in_ready", in_ready, need && out_ready);
      if (out_valid) begin
        t = tag;
        if (pad && k >= total - 8) t = "R7";
        if (!out_ready) t = "R12";
        chk(out_data == exp_byte(k, pad, r, len), t, out_data, exp_byte(k, pad, r, len));
        chk(out_last == (total == 64 || k >= 64), (total == 128) ? "R4 last" : tag,
            out_last, (total == 64 || k >= 64));
        chk(out_eob == (k % 64 == 63), "R10", out_eob, (k % 64 == 63));
      end
      if (out_valid && out_ready) k++;
      @(negedge clk);
    end
    start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    #1;
    chk(guard < 4000, "R9 progress", guard, 4000);
    chk(idle == 1'b1, tag, idle, 1);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    #1;
    chk(idle == 1'b1, "R1 idle", idle, 1);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b0, "R1 in_ready", in_ready, 0);
    rst_n = 1'b1;
    run(1'b0, 17, 32'hdeadbeef, 32'h01234567, 1'b0, "R2");
    run(1'b1, 0, 32'h0, 32'h0, 1'b0, "R6");
    run(1'b1, 13, 32'h00000068, 32'h0, 1'b0, "R3");
    run(1'b1, 55, 32'h89abcdef, 32'h76543210, 1'b0, "R3");
    run(1'b1, 56, 32'h000001c0, 32'h0, 1'b0, "R4");
    run(1'b1, 63, 32'hcafef00d, 32'h00000001, 1'b0, "R4");
    run(1'b1, 64, 32'h00000200, 32'h0, 1'b0, "R5");
    run(1'b1, 100, 32'h11223344, 32'h55667788, 1'b0, "R8");
    run(1'b1, 30, 32'ha5a5a5a5, 32'h5a5a5a5a, 1'b1, "R11");
    run(1'b0, 0, 32'h0, 32'h0, 1'b1, "R11");
    for (int n = 0; n < 24; n++)
      run(1'($urandom % 4 != 0), int'($urandom % 66), $urandom, $urandom, 1'b0, "R7");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule